// File: doc/BRIEF.md
# I2C Bus Event Monitor

This block listens to the two wires of an I2C bus without driving either of them. It turns what it sees into a stream of short event records. The bus lines are raw asynchronous inputs. Each line passes through a synchronizer and a glitch filter that runs on the system clock. Edges of the filtered lines are then decoded into bus conditions and 9-bit transfer units.

Each record is valid for one system clock cycle and holds three fields: an event code, an 8-bit value and an acknowledge flag. The decoder has three phases: idle (waiting for a START), gathering the address byte, and gathering data bytes. A transaction can carry any number of data bytes. It closes with a STOP, or with a new START that is reported as a repeated START. Software or a trace buffer downstream reads the stream to rebuild the traffic.

Top module: `i2c_bus_monitor`

## Requirements
- R1: An SDA fall while SCL is high, seen in the idle phase, emits event code 0 (START) and moves to address gathering.
- R2: An SDA fall while SCL is high, seen in the data phase, emits code 1 (repeated START), clears the bit count and returns to address gathering.
- R3: An SDA rise while SCL is high, seen in the data phase, emits code 2 (STOP) and returns to idle. The same pattern in the idle phase emits nothing.
- R4: Bits are taken on each SCL rising edge, most significant bit first. One unit is 8 bits followed by an acknowledge bit, and no byte event is emitted before the ninth bit.
- R5: For the first unit after a START, byte bit 0 selects the direction (1 read, 0 write). The event is code 4 (read) or code 3 (write), and its value is the upper 7 bits, zero-extended to 8 bits.
- R6: Each later unit emits code 6 if the latched direction is read, or code 5 if it is write, with all 8 bits as the value. Any number of such units may follow.
- R7: The acknowledge flag of a byte event is the ninth sampled SDA level: 1 means NACK, 0 means ACK.
- R8: While the address byte is being gathered, START and STOP patterns on the lines are ignored and bit counting continues.
- R9: START, repeated START and STOP events carry a value of 0 and a flag of 0.
- R10: A level on either line that lasts fewer than FILT_LEN system clocks after synchronization is filtered out and causes no event.
- R11: The line levels present when reset is released are taken as the starting reference, and no edge is inferred from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| evt_valid_o | output | 1 | Event record valid for this cycle |
| evt_code_o | output | 3 | Event code (0..6, see R1-R6) |
| evt_value_o | output | 8 | Address or data value |
| evt_nack_o | output | 1 | 1 = NACK on the ninth bit |

## Verification
Directed transactions cover three cases: a write with ACKed and NACKed data, a read followed by a repeated START into a write, and a STOP pattern on an idle bus. Together they separate how the direction bit is latched and how the repeated START is reported. A short SDA pulse in idle tests the filter. A STOP-then-START pattern inside an address bit shows that conditions are ignored during the address byte, because a wrong decoder would split that byte. Seeded random transactions then mix addresses, directions, byte counts, ACK values and endings, each compared against a record list that the bench builds.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR_WR = 3'd3,
    EV_ADDR_RD = 3'd4,
    EV_DATA_WR = 3'd5,
    EV_DATA_RD = 3'd6
  } evt_code_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } mon_state_e;

  typedef struct packed {
    logic      valid;
    evt_code_e code;
    logic [7:0] value;
    logic      nack;
  } evt_rec_t;

endpackage

// File: rtl/i2cmon_line_filter.sv
module i2cmon_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic load_i,
  output logic line_o
);

  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign sync_out = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN <= 1) begin : g_bypass
      logic filt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= 1'b1;
        else        filt_q <= sync_out;
      end
      assign line_o = filt_q;
    end else begin : g_filter
      logic          filt_q, filt_d;
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        filt_d = filt_q;
        cnt_d  = cnt_q;
        if (load_i) begin
          filt_d = sync_out;
          cnt_d  = '0;
        end else if (sync_out == filt_q) begin
          cnt_d = '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
          filt_d = sync_out;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          filt_q <= filt_d;
          cnt_q  <= cnt_d;
        end
      end

      assign line_o = filt_q;

      // R10: an output change needs the synchronized input to disagree first
      p_filter_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && sync_out == filt_q) |=> $stable(filt_q));
    end
  endgenerate

endmodule

// File: rtl/i2cmon_edge.sv
module i2cmon_edge #(
  parameter int WARM_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic warm_o,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o
);

  localparam int WW = $clog2(WARM_CYC + 1);

  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          armed_q;
  logic          scl_prev_q, sda_prev_q;

  assign warm_o = (wcnt_q != WW'(WARM_CYC));

  always_comb begin
    wcnt_d = wcnt_q;
    if (warm_o) wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q     <= '0;
      armed_q    <= 1'b0;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      wcnt_q     <= wcnt_d;
      armed_q    <= !warm_o;
      scl_prev_q <= scl_i;
      sda_prev_q <= sda_i;
    end
  end

  assign scl_rise_o = armed_q && !scl_prev_q && scl_i;
  assign start_o    = armed_q && sda_prev_q && !sda_i && scl_i;
  assign stop_o     = armed_q && !sda_prev_q && sda_i && scl_i;

  // R11: no edge reported in the cycle after a warm-up cycle
  p_quiet_warmup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    warm_o |=> !(scl_rise_o || start_o || stop_o));

endmodule

// File: rtl/i2cmon_decoder.sv
module i2cmon_decoder
  import i2cmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_rise_i,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     sda_i,
  output evt_rec_t evt_o
);

  mon_state_e state_q, state_d;
  logic [3:0] bitcnt_q, bitcnt_d;
  logic [7:0] shreg_q, shreg_d;
  logic       rd_q, rd_d;
  logic       rep_q, rep_d;
  evt_rec_t   evt_q, evt_d;

  logic do_bit, do_start, do_stop;

  assign do_bit   = scl_rise_i && (state_q != ST_WAIT);
  assign do_start = start_i && !scl_rise_i &&
                    ((state_q == ST_WAIT) || (state_q == ST_DATA));
  assign do_stop  = stop_i && !scl_rise_i && !start_i && (state_q == ST_DATA);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    rd_d     = rd_q;
    rep_d    = rep_q;
    evt_d    = '0;
    if (do_bit) begin
      if (bitcnt_q == 4'd8) begin
        bitcnt_d   = '0;
        evt_d.valid = 1'b1;
        evt_d.nack  = sda_i;
        if (state_q == ST_ADDR) begin
          rd_d        = shreg_q[0];
          evt_d.code  = shreg_q[0] ? EV_ADDR_RD : EV_ADDR_WR;
          evt_d.value = {1'b0, shreg_q[7:1]};
          state_d     = ST_DATA;
        end else begin
          evt_d.code  = rd_q ? EV_DATA_RD : EV_DATA_WR;
          evt_d.value = shreg_q;
        end
      end else begin
        shreg_d  = {shreg_q[6:0], sda_i};
        bitcnt_d = bitcnt_q + 1'b1;
      end
    end else if (do_start) begin
      evt_d.valid = 1'b1;
      evt_d.code  = rep_q ? EV_RSTART : EV_START;
      state_d     = ST_ADDR;
      bitcnt_d    = '0;
      rep_d       = 1'b1;
      rd_d        = 1'b0;
    end else if (do_stop) begin
      evt_d.valid = 1'b1;
      evt_d.code  = EV_STOP;
      state_d     = ST_WAIT;
      rep_d       = 1'b0;
      rd_d        = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_WAIT;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rd_q     <= 1'b0;
      rep_q    <= 1'b0;
      evt_q    <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      rd_q     <= rd_d;
      rep_q    <= rep_d;
      evt_q    <= evt_d;
    end
  end

  assign evt_o = evt_q;

  // R4: a unit never holds more than 8 pending bits before its ninth
  p_bitcnt_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= 4'd8);

  // R5: an address event leaves the decoder in the data phase
  p_addr_to_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q.valid && (evt_q.code == EV_ADDR_WR || evt_q.code == EV_ADDR_RD))
    |-> state_q == ST_DATA);

  // R3: a STOP event leaves the decoder idle with the repeat flag cleared
  p_stop_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q.valid && evt_q.code == EV_STOP) |-> (state_q == ST_WAIT && !rep_q));

  // R3: the idle phase is silent unless a START is seen
  p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !start_i) |=> !evt_q.valid);

  // R9: bus-condition events carry empty value and flag
  p_ctrl_fields_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q.valid && evt_q.code <= EV_STOP) |-> (evt_q.value == 8'd0 && !evt_q.nack));

  // R6: a data-read event only occurs while the read direction is latched
  p_dir_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q.valid && evt_q.code == EV_DATA_RD) |-> rd_q);

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       evt_valid_o,
  output logic [2:0] evt_code_o,
  output logic [7:0] evt_value_o,
  output logic       evt_nack_o
);

  localparam int WARM_CYC = SYNC_STAGES + 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic scl_f, sda_f, warm;
  logic scl_rise, start_det, stop_det;
  evt_rec_t evt;

  i2cmon_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n_int), .line_i(scl_i), .load_i(warm), .line_o(scl_f)
  );

  i2cmon_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n_int), .line_i(sda_i), .load_i(warm), .line_o(sda_f)
  );

  i2cmon_edge #(.WARM_CYC(WARM_CYC)) u_edge (
    .clk(clk), .rst_n(rst_n_int), .scl_i(scl_f), .sda_i(sda_f),
    .warm_o(warm), .scl_rise_o(scl_rise), .start_o(start_det), .stop_o(stop_det)
  );

  i2cmon_decoder u_dec (
    .clk(clk), .rst_n(rst_n_int), .scl_rise_i(scl_rise), .start_i(start_det),
    .stop_i(stop_det), .sda_i(sda_f), .evt_o(evt)
  );

  assign evt_valid_o = evt.valid;
  assign evt_code_o  = evt.code;
  assign evt_value_o = evt.value;
  assign evt_nack_o  = evt.nack;

  // R1: no event record is presented while the internal reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_int |=> !evt_valid_o);

endmodule

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;

  localparam int FILT_LEN = 4;
  localparam int HALF     = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl, sda;
  logic       evt_valid_o;
  logic [2:0] evt_code_o;
  logic [7:0] evt_value_o;
  logic       evt_nack_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [11:0] exp_q[$];
  logic [11:0] obs_q[$];
  bit          rep_flag = 1'b0;
  bit          rd_flag  = 1'b0;

  always #5 clk = ~clk;

  i2c_bus_monitor #(.SYNC_STAGES(2), .FILT_LEN(FILT_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o),
    .evt_value_o(evt_value_o), .evt_nack_o(evt_nack_o)
  );

  always @(negedge clk)
    if (evt_valid_o) obs_q.push_back({evt_code_o, evt_value_o, evt_nack_o});

  function automatic logic [11:0] mk(input int code, input logic [7:0] v, input logic n);
    return {3'(code), v, n};
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 1'b0; hold(HALF);
    sda = 1'b1; hold(HALF);
    scl = 1'b1; hold(HALF);
    sda = 1'b0; hold(HALF);
    scl = 1'b0; hold(HALF);
    exp_q.push_back(mk(rep_flag ? 1 : 0, 8'h00, 1'b0));  // R1 / R2 / R9
    rep_flag = 1'b1;
    rd_flag  = 1'b0;
  endtask

  task automatic bus_stop(input bit expect_evt);
    scl = 1'b0; hold(HALF);
    sda = 1'b0; hold(HALF);
    scl = 1'b1; hold(HALF);
    sda = 1'b1; hold(HALF);
    if (expect_evt) exp_q.push_back(mk(2, 8'h00, 1'b0));  // R3 / R9
    rep_flag = 1'b0;
    rd_flag  = 1'b0;
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    scl = 1'b0; sda = b; hold(HALF);
    scl = 1'b1;
    if (glitch) begin
      hold(HALF/2); sda = ~b; hold(HALF/2); sda = b; hold(HALF/2);
    end else begin
      hold(HALF);
    end
    scl = 1'b0;
  endtask

  // R4 / R5 / R6 / R7: one 9-bit unit and its expected record
  task automatic send_byte(input logic [7:0] b, input logic nack, input bit is_addr, input int glitch_idx);
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == glitch_idx);
    send_bit(nack, 1'b0);
    if (is_addr) begin
      rd_flag = b[0];
      exp_q.push_back(mk(b[0] ? 4 : 3, {1'b0, b[7:1]}, nack));
    end else begin
      exp_q.push_back(mk(rd_flag ? 6 : 5, b, nack));
    end
  endtask

  task automatic check_events(input string tag);
    int n;
    hold(40);
    n_checks++;
    if (obs_q.size() != exp_q.size()) begin
      n_fails++;
      $display("FAIL %s: event count actual %0d expected %0d", tag, obs_q.size(), exp_q.size());
    end
    n = (obs_q.size() < exp_q.size()) ? obs_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      n_checks++;
      if (obs_q[i] !== exp_q[i]) begin
        n_fails++;
        $display("FAIL %s: event %0d actual code=%0d val=%02h nack=%0b expected code=%0d val=%02h nack=%0b",
                 tag, i, obs_q[i][11:9], obs_q[i][8:1], obs_q[i][0],
                 exp_q[i][11:9], exp_q[i][8:1], exp_q[i][0]);
      end
    end
    obs_q.delete();
    exp_q.delete();
  endtask

  initial begin
    int timer = 0;
    while (!done && timer < 150000) begin
      @(posedge clk);
      timer++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    bit open_txn;
    void'($urandom(32'd4242));
    // R11: bus held with SDA low and SCL high across reset release
    rst_n = 1'b0; scl = 1'b1; sda = 1'b0;
    hold(6);
    n_checks++;
    if (evt_valid_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset: evt_valid actual %0b expected 0", evt_valid_o);
    end
    rst_n = 1'b1;
    hold(60);
    sda = 1'b1;                         // SDA rise with SCL high while idle
    check_events("R11 levels at reset release");

    // R10: SDA pulse shorter than the filter length in idle
    sda = 1'b0; hold(FILT_LEN - 1); sda = 1'b1;
    check_events("R10 short SDA pulse");

    // R3: STOP pattern on an idle bus
    bus_stop(1'b0);
    check_events("R3 idle STOP ignored");

    // R1 R4 R5 R7 R9: write with ACKed and NACKed data
    bus_start();
    send_byte(8'hA0, 1'b0, 1'b1, -1);
    send_byte(8'h81, 1'b0, 1'b0, -1);
    send_byte(8'h00, 1'b1, 1'b0, -1);
    bus_stop(1'b1);
    check_events("R1 R4 R5 R7 R9 write transaction");

    // R2 R5 R6: read, repeated START, then write
    bus_start();
    send_byte(8'h37, 1'b0, 1'b1, -1);
    send_byte(8'hFF, 1'b1, 1'b0, -1);
    bus_start();
    send_byte(8'h36, 1'b0, 1'b1, -1);
    send_byte(8'h5A, 1'b0, 1'b0, -1);
    bus_stop(1'b1);
    check_events("R2 R5 R6 read then repeated START write");

    // R8: STOP then START pattern inside an address bit
    bus_start();
    send_byte(8'hA4, 1'b0, 1'b1, 1);
    send_byte(8'h3C, 1'b1, 1'b0, -1);
    bus_stop(1'b1);
    check_events("R8 conditions ignored in address byte");

    // R4 R5 R6 R7 R2 R3: seeded random transactions
    open_txn = 1'b0;
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      logic       rw;
      int         nb;
      a  = 7'($urandom);
      rw = 1'($urandom);
      nb = $urandom % 4;
      bus_start();
      send_byte({a, rw}, 1'($urandom), 1'b1, -1);
      for (int k = 0; k < nb; k++) send_byte(8'($urandom), 1'($urandom), 1'b0, -1);
      open_txn = (($urandom % 3) == 0);
      if (!open_txn) bus_stop(1'b1);
      check_events("R4 R5 R6 R7 random transaction");
    end
    if (open_txn) begin
      bus_stop(1'b1);
      check_events("R3 closing STOP");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule